// File: doc/BRIEF.md
# Residue-Coded Address Index and Increment Unit

This unit forms program addresses that carry their own error-detecting code. Each coded address is 20 bits wide: a 16-bit binary address and a 4-bit check symbol tied to the address's residue modulo 15. The unit keeps one sequence register and two index registers, all holding coded addresses. It can step the sequence address by one, or form an indexed address by adding a selected index register to an incoming coded instruction address.

The check symbol is never recomputed from the new binary address. Instead, the symbols of the two operands are added modulo 15 with an end-around carry, so the code travels through the arithmetic. Every result then passes through an independent code checker before it reaches the outputs. A failed check raises a fault output. A carry out of the 16-bit address add would break the residue relation, so it is reported as an overflow. In both cases the result is not written into any register.

Top module: `rca_addr_unit`

## Requirements
- R1: A synchronous active-low reset clears `valid_o`, `check_ok_o`, `overflow_o` and `fault_o`, and sets the sequence register and both index registers to the coded zero address (address 0, symbol 4'hF).
- R2: A coded address has its address in bits [19:4] and its check symbol in bits [3:0]. It is valid only when symbol == 15 - (address mod 15). For every result, `check_ok_o` is high exactly when the presented `addr_o` is valid.
- R3: `op_i` = 5 (index 0) or 6 (index 1) presents, on `addr_o`, the sum of the instruction address and the selected index address, with symbol s = a + b (or s - 15 when s > 15) of the two operand symbols. An index operation writes no register.
- R4: `op_i` = 4 adds 1 to the sequence address and combines its symbol with 14 using the same modulo-15 rule. The coded result is presented on `addr_o` and written back to the sequence register.
- R5: A carry out of the 16-bit address add sets `overflow_o`. `addr_o` then carries the low 16 address bits, and no register is written.
- R6: `fault_o` is high exactly for a presented result that fails the code check, and such a result is not written to any register.
- R7: `op_i` = 1, 2 and 3 load `instr_i` unchanged into the sequence register, index register 0 and index register 1 respectively. The loaded value is also presented on `addr_o` and checked.
- R8: A result appears on the outputs on the clock edge after the operation is presented, with `valid_o` high for that one cycle. `op_i` = 0 and 7 produce `valid_o` = 0, `overflow_o` = 0 and `fault_o` = 0, and change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Operation: 0 none, 1 load sequence, 2 load index 0, 3 load index 1, 4 increment, 5 index 0, 6 index 1, 7 none |
| instr_i | input | 20 | Coded instruction address or load value |
| addr_o | output | 20 | Coded result address |
| valid_o | output | 1 | Result present this cycle |
| check_ok_o | output | 1 | Result passed the code check |
| overflow_o | output | 1 | Address add carried out of 16 bits |
| fault_o | output | 1 | Result failed the code check |

## Verification
Increments are tried at several points:
- from the reset value;
- across a residue wrap from 14 to 15, where the symbol must become 4'hF rather than 0;
- at address 16'hFFFF, which must overflow and leave the register unchanged.

Index operations pair operands whose residues sum to less than 15, to exactly 15 and to more than 15, which tells apart a wrong end-around carry from a correct one. Sums that carry out of 16 bits separate overflow reporting from silent wrapping. Loads and index inputs with corrupted symbols, including symbol 0 on a multiple of 15, show that bad codes raise a fault and are never stored. A reset in the middle of a run shows that the registers return to the coded zero address.

// File: rtl/rca_pkg.sv
// Package: shared operation codes and sizes for the residue-coded address unit.
// Assumes the address width is a whole multiple of the check-symbol width.
package rca_pkg;

    // Operation codes presented on op_i.
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_LD_SEQ = 3'd1,
        OP_LD_X0  = 3'd2,
        OP_LD_X1  = 3'd3,
        OP_INC    = 3'd4,
        OP_IDX0   = 3'd5,
        OP_IDX1   = 3'd6,
        OP_RSV    = 3'd7
    } op_e;

    // Number of index registers reachable through the op codes above.
    localparam int NUM_IDX = 2;

endpackage

// File: rtl/rca_eac_add.sv
// Module: W-bit ones'-complement adder with end-around carry.
// Computes a + b modulo (2^W - 1). An all-ones result stands for zero.
// Assumes nothing about its inputs; a second carry cannot occur.
module rca_eac_add #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    logic [W:0] raw;

    // Plain add, then fold the carry back into bit 0.
    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        sum = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    end
endmodule

// File: rtl/rca_residue.sv
// Module: residue of an AW-bit value modulo (2^CW - 1), normalised to 0..2^CW-2.
// Folds CW-bit chunks through a chain of end-around-carry adders.
// Assumes AW is a multiple of CW.
module rca_residue #(
    parameter int AW = 16,
    parameter int CW = 4
) (
    input  logic [AW-1:0] val,
    output logic [CW-1:0] res
);
    localparam int NCH = AW / CW;

    logic [CW-1:0] part [NCH];

    assign part[0] = val[CW-1:0];

    // One adder per further chunk: 2^CW == 1 modulo (2^CW - 1).
    for (genvar i = 1; i < NCH; i++) begin : g_fold
        rca_eac_add #(.W(CW)) u_add (
            .a  (part[i-1]),
            .b  (val[i*CW +: CW]),
            .sum(part[i])
        );
    end

    // The all-ones form of zero is mapped to 0.
    always_comb begin
        res = (part[NCH-1] == {CW{1'b1}}) ? {CW{1'b0}} : part[NCH-1];
    end
endmodule

// File: rtl/rca_code_check.sv
// Module: checker for one coded address {address, symbol}.
// The code is valid when residue(address) plus symbol, summed modulo 15
// with end-around carry, gives all ones.
// Assumes the symbol sits in the low CW bits.
module rca_code_check #(
    parameter int AW = 16,
    parameter int CW = 4
) (
    input  logic [AW+CW-1:0] code,
    output logic             ok
);
    logic [CW-1:0] res;
    logic [CW-1:0] tot;

    rca_residue #(.AW(AW), .CW(CW)) u_res (
        .val(code[AW+CW-1:CW]),
        .res(res)
    );

    rca_eac_add #(.W(CW)) u_sum (
        .a  (res),
        .b  (code[CW-1:0]),
        .sum(tot)
    );

    // Valid only for the all-ones total.
    always_comb begin
        ok = (tot == {CW{1'b1}});
    end
endmodule

// File: rtl/rca_addr_unit.sv
// Module: residue-coded address unit (top).
// Holds a coded sequence register and NUM_IDX coded index registers.
// Increments the sequence address and forms indexed addresses.
// Check symbols are added modulo (2^CHK_W - 1) rather than regenerated.
// Every result is code-checked before it is registered out.
// A result that fails the check, or carries out of the address add, is not stored.
// Assumes ADDR_W is a multiple of CHK_W, so 2^ADDR_W == 1 modulo the check base.
module rca_addr_unit
    import rca_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CHK_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               op_i,
    input  logic [ADDR_W+CHK_W-1:0]  instr_i,
    output logic [ADDR_W+CHK_W-1:0]  addr_o,
    output logic                     valid_o,
    output logic                     check_ok_o,
    output logic                     overflow_o,
    output logic                     fault_o
);
    localparam int CODE_W = ADDR_W + CHK_W;
    // Coded zero: address 0 with the all-ones symbol.
    localparam logic [CODE_W-1:0] ZERO_CODE = {{ADDR_W{1'b0}}, {CHK_W{1'b1}}};
    // Coded one: address 1 with symbol (2^CHK_W - 1) - 1.
    localparam logic [CODE_W-1:0] ONE_CODE  =
        {ADDR_W'(1), {{(CHK_W-1){1'b1}}, 1'b0}};

    op_e               op;
    op_e               op_q;
    logic [CODE_W-1:0] seq_q;
    logic [CODE_W-1:0] idx_q [NUM_IDX];

    logic [CODE_W-1:0] opa;
    logic [CODE_W-1:0] opb;
    logic [ADDR_W:0]   addr_sum;
    logic [CHK_W-1:0]  sym_sum;
    logic [CODE_W-1:0] result;
    logic              carry;
    logic              is_load;
    logic              is_arith;
    logic              res_ok;
    logic              commit;
    logic              out_chk_ok;

    assign op = op_e'(op_i);

    // Choose adder operands: sequence + coded one, or instruction + index.
    always_comb begin
        opa = instr_i;
        opb = ZERO_CODE;
        case (op)
            OP_INC:  begin opa = seq_q;   opb = ONE_CODE;  end
            OP_IDX0: begin opa = instr_i; opb = idx_q[0];  end
            OP_IDX1: begin opa = instr_i; opb = idx_q[1];  end
            default: begin opa = instr_i; opb = ZERO_CODE; end
        endcase
    end

    // Binary address add with its carry kept for overflow reporting.
    always_comb begin
        addr_sum = {1'b0, opa[CODE_W-1:CHK_W]} + {1'b0, opb[CODE_W-1:CHK_W]};
    end

    // Check symbols combine modulo (2^CHK_W - 1).
    rca_eac_add #(.W(CHK_W)) u_sym_add (
        .a  (opa[CHK_W-1:0]),
        .b  (opb[CHK_W-1:0]),
        .sum(sym_sum)
    );

    // Classify the operation and pick the result: loads bypass the adder.
    always_comb begin
        is_load  = (op == OP_LD_SEQ) || (op == OP_LD_X0) || (op == OP_LD_X1);
        is_arith = (op == OP_INC) || (op == OP_IDX0) || (op == OP_IDX1);
        result   = is_load ? instr_i : {addr_sum[ADDR_W-1:0], sym_sum};
        carry    = is_arith && addr_sum[ADDR_W];
    end

    // Independent code check on the result before it is stored or driven.
    rca_code_check #(.AW(ADDR_W), .CW(CHK_W)) u_res_chk (
        .code(result),
        .ok  (res_ok)
    );

    // A register is written only with a result that is in code and in range.
    assign commit = res_ok && !carry;

    // Sequence register: written by its load and by increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= ZERO_CODE;
        end else if (commit && (op == OP_LD_SEQ || op == OP_INC)) begin
            seq_q <= result;
        end
    end

    // Index registers: one per load code, written only by their own load.
    for (genvar k = 0; k < NUM_IDX; k++) begin : g_idx
        localparam logic [2:0] LD_CODE = 3'(int'(OP_LD_X0) + k);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                idx_q[k] <= ZERO_CODE;
            end else if (commit && op_i == LD_CODE) begin
                idx_q[k] <= result;
            end
        end
    end

    // Output stage: one cycle after the operation, flags only with a result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o     <= '0;
            valid_o    <= 1'b0;
            check_ok_o <= 1'b0;
            overflow_o <= 1'b0;
            fault_o    <= 1'b0;
            op_q       <= OP_NOP;
        end else begin
            op_q <= op;
            if (is_load || is_arith) begin
                addr_o     <= result;
                valid_o    <= 1'b1;
                check_ok_o <= res_ok;
                overflow_o <= carry;
                fault_o    <= !res_ok;
            end else begin
                valid_o    <= 1'b0;
                check_ok_o <= 1'b0;
                overflow_o <= 1'b0;
                fault_o    <= 1'b0;
            end
        end
    end

    // Second checker on the registered output, used to guard the first.
    rca_code_check #(.AW(ADDR_W), .CW(CHK_W)) u_out_chk (
        .code(addr_o),
        .ok  (out_chk_ok)
    );

    // R2: the reported check result agrees with a fresh check of addr_o.
    a_r2_check_matches: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (out_chk_ok == check_ok_o));

    // R3: an index operation leaves the sequence register untouched.
    a_r3_index_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && (op_q == OP_IDX0 || op_q == OP_IDX1)) |-> $stable(seq_q));

    // R4: an increment that did not overflow steps the address by one.
    a_r4_incr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && op_q == OP_INC && !overflow_o) |->
        (addr_o[CODE_W-1:CHK_W] == $past(seq_q[CODE_W-1:CHK_W]) + ADDR_W'(1)));

    // R5: an overflowing increment does not disturb the sequence register.
    a_r5_no_overflow_write: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && overflow_o && op_q == OP_INC) |-> (seq_q == $past(seq_q)));

    // R8: with no result presented, no flag is raised.
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (!fault_o && !overflow_o && !check_ok_o));

endmodule

// File: tb/rca_addr_unit_tb.sv
// Bench for rca_addr_unit: a table of operations walked by one loop against a
// requirement-level model, then directed reset and corner-case tests.
module rca_addr_unit_tb;
    localparam int AW = 16;
    localparam int CW = 4;
    localparam int NV = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [19:0] instr_i = '0;
    logic [19:0] addr_o;
    logic        valid_o, check_ok_o, overflow_o, fault_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [19:0] m_seq;
    logic [19:0] m_idx [2];

    // Entry layout: {op[2:0], corrupt symbol, address[15:0]}.
    localparam logic [19:0] VEC [NV] = '{
        {3'd2, 1'b0, 16'h0100},   // load index 0
        {3'd3, 1'b0, 16'h1234},   // load index 1
        {3'd1, 1'b0, 16'h00FE},   // load sequence
        {3'd4, 1'b0, 16'h0000},   // increment
        {3'd4, 1'b0, 16'h0000},   // increment
        {3'd5, 1'b0, 16'h2000},   // index 0
        {3'd6, 1'b0, 16'h0ABC},   // index 1
        {3'd6, 1'b0, 16'hEDCC},   // index 1, carries out
        {3'd1, 1'b1, 16'h0050},   // bad load of sequence
        {3'd4, 1'b0, 16'h0000},   // increment (shows no write)
        {3'd5, 1'b1, 16'h0003},   // index with bad instruction symbol
        {3'd6, 1'b0, 16'h0007},   // index 1, residues sum past 15
        {3'd2, 1'b0, 16'hFFFF},   // load index 0 with top address
        {3'd5, 1'b0, 16'h0001}    // index 0, carries out
    };

    rca_addr_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op_i),
        .instr_i   (instr_i),
        .addr_o    (addr_o),
        .valid_o   (valid_o),
        .check_ok_o(check_ok_o),
        .overflow_o(overflow_o),
        .fault_o   (fault_o)
    );

    always #5 clk = ~clk;

    // Coded form of an address: symbol is 15 minus the residue modulo 15.
    function automatic logic [19:0] mk(input logic [15:0] a);
        return {a, 4'(15 - (int'(a) % 15))};
    endfunction

    // Modulo-15 symbol sum with the all-ones form of zero.
    function automatic logic [3:0] msum(input logic [3:0] x, input logic [3:0] y);
        int s;
        s = int'(x) + int'(y);
        return 4'((s > 15) ? s - 15 : s);
    endfunction

    function automatic bit code_ok(input logic [19:0] c);
        return int'(c[3:0]) == 15 - (int'(c[19:4]) % 15);
    endfunction

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_seq = mk(16'h0);
        m_idx[0] = mk(16'h0);
        m_idx[1] = mk(16'h0);
    endtask

    // Present one operation at a falling edge and check the result one edge later.
    task automatic run(input logic [2:0] op, input logic [19:0] code, input string req);
        logic [19:0] r;
        logic [16:0] s;
        bit ovf, ok, act;
        act = 1'b1; ovf = 1'b0; r = '0;
        case (op)
            3'd1, 3'd2, 3'd3: r = code;
            3'd4: begin
                s = {1'b0, m_seq[19:4]} + 17'd1;
                r = {s[15:0], msum(m_seq[3:0], 4'd14)};
                ovf = s[16];
            end
            3'd5, 3'd6: begin
                s = {1'b0, code[19:4]} + {1'b0, m_idx[op - 3'd5][19:4]};
                r = {s[15:0], msum(code[3:0], m_idx[op - 3'd5][3:0])};
                ovf = s[16];
            end
            default: act = 1'b0;
        endcase
        ok = act && code_ok(r);
        op_i = op;
        instr_i = code;
        @(negedge clk);
        op_i = 3'd0;
        check_eq(req, "valid", 32'(valid_o), 32'(act));
        check_eq(req, "overflow", 32'(overflow_o), 32'(act && ovf));
        check_eq(req, "fault", 32'(fault_o), 32'(act && !ok));
        if (act) begin
            check_eq(req, "addr", 32'(addr_o), 32'(r));
            check_eq(req, "check_ok", 32'(check_ok_o), 32'(ok));
        end
        if (ok && !ovf) begin
            if (op == 3'd1 || op == 3'd4) m_seq = r;
            if (op == 3'd2) m_idx[0] = r;
            if (op == 3'd3) m_idx[1] = r;
        end
    endtask

    // Requirement tag for each table entry, by operation and kind.
    function automatic string vec_req(input logic [19:0] v);
        if (v[16]) return "R6";
        case (v[19:17])
            3'd4: return "R4";
            3'd5, 3'd6: return "R3";
            default: return "R7";
        endcase
    endfunction

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs quiet after reset.
        check_eq("R1", "valid", 32'(valid_o), 32'd0);
        check_eq("R1", "fault", 32'(fault_o), 32'd0);
        check_eq("R1", "overflow", 32'(overflow_o), 32'd0);
        check_eq("R1", "check_ok", 32'(check_ok_o), 32'd0);
        // R1: registers hold coded zero; increment gives address 1, symbol 14.
        run(3'd4, 20'h0, "R1");
        check_eq("R1", "incr value", 32'(addr_o), 32'h0001E);
        run(3'd5, mk(16'h0), "R1");
        check_eq("R1", "index zero", 32'(addr_o), 32'h0000F);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            logic [19:0] c;
            c = mk(VEC[i][15:0]);
            if (VEC[i][16]) c[3:0] = c[3:0] ^ 4'h5;
            run(VEC[i][19:17], c, vec_req(VEC[i]));
        end

        // R2: symbol 0 on a multiple of 15 is not a valid code (canonical is 15).
        run(3'd3, {16'h001E, 4'h0}, "R2");
        // R5: sequence at the top address overflows and stays put.
        run(3'd1, mk(16'hFFFF), "R5");
        run(3'd4, 20'h0, "R5");
        run(3'd4, 20'h0, "R5");
        check_eq("R5", "held address", 32'(addr_o[19:4]), 32'h0000);
        // R4: residue 14 -> 0 across the increment; symbol must become 15.
        run(3'd1, mk(16'h000E), "R4");
        run(3'd4, 20'h0, "R4");
        check_eq("R4", "wrap symbol", 32'(addr_o[3:0]), 32'hF);
        // R8: idle codes give no result and change nothing.
        run(3'd0, mk(16'h1111), "R8");
        run(3'd7, mk(16'h2222), "R8");
        run(3'd4, 20'h0, "R8");
        check_eq("R8", "seq after idle", 32'(addr_o[19:4]), 32'h0010);

        // R1: reset in the middle of a run returns registers to coded zero.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check_eq("R1", "valid after reset", 32'(valid_o), 32'd0);
        run(3'd4, 20'h0, "R1");
        run(3'd6, mk(16'h0), "R1");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule